// File: doc/BRIEF.md
# ADC Conversion Result Front End

This block sits between an abstract analog-to-digital converter and the on-chip register bus. It starts conversions, either when software writes a start bit or on the rising edge of an external trigger if triggering is enabled. It catches every result the converter returns in a single last-result register and keeps two status flags: result ready and result lost (overrun).

Software can service the block through an interrupt or through a DMA channel. The interrupt line raises any status flag whose enable bit has been set. Software clears the flags with write-one-to-clear writes. When DMA mode is on, a DMA request is raised while a result waits. The DMA acknowledge clears the ready flag in hardware. A result that is overwritten before it was consumed sets the overrun flag in both modes. A resolution field narrows each captured result to 8, 10, 11 or 12 significant bits when the converter is 12 bits wide.

The register port has no wait states. Writes take effect at the next clock edge. Reads are combinational from the selected address. Register map, using `reg_addr`: 0 control, 1 status, 2 interrupt-enable set, 3 interrupt-enable clear, 4 interrupt mask readback, 5 status clear, 6 last result. Unused addresses read as zero.

Top module: `adc_result_frontend`

## Requirements
- R1: A write to address 0 with bit 0 set produces a `conv_req` pulse that is high for exactly the one cycle after the write edge. The same write loads bit 1 (trigger enable), bit 2 (DMA enable) and bits 5:4 (resolution code), and these read back at the same positions.
- R2: While trigger enable is set, a rising edge on `ext_trig` produces one `conv_req` pulse in the following cycle. Holding `ext_trig` high produces no further pulses. While trigger enable is clear, `ext_trig` has no effect on `conv_req`.
- R3: A start write and a trigger rising edge in the same cycle produce a single one-cycle `conv_req` pulse.
- R4: On `conv_done` the last-result register (address 6, also `dma_data`) takes `conv_data`, overwriting any earlier value whether it was read or not. Only the low DATA_W-4, DATA_W-2, DATA_W-1 or DATA_W bits are kept, for resolution codes 0, 1, 2 and 3. The upper bits read as zero.
- R5: `conv_done` sets the ready flag (status bit 0) from the next cycle on.
- R6: If `conv_done` arrives while the ready flag is set, and the old result is neither DMA-acknowledged nor cleared in that same cycle, the overrun flag (status bit 1) is set.
- R7: The overrun flag stays set until a write of one to bit 1 at address 5. Reading the result, clearing the ready flag and DMA acknowledges leave it set.
- R8: `irq` is high when a status flag is set and its mask bit is set. Mask bits use the same positions as status bits. A write to address 2 sets the mask bits written as one, a write to address 3 clears them, and address 4 reads the mask.
- R9: Writing one to bit 0 at address 5 clears the ready flag. Zero bits in that write change nothing.
- R10: With DMA enable set, `dma_req` is high while the ready flag is set. A `dma_ack` during `dma_req` clears the ready flag, and `dma_req` is low in the cycle that follows the acknowledge.
- R11: When `conv_done` coincides with an accepted `dma_ack`, the new result is kept, the ready flag stays set, and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| ext_trig | input | 1 | External conversion trigger level |
| conv_req | output | 1 | One-cycle conversion request to the converter |
| conv_done | input | 1 | Converter result valid, one cycle |
| conv_data | input | DATA_W | Converter result |
| irq | output | 1 | Interrupt line |
| dma_req | output | 1 | DMA service request |
| dma_ack | input | 1 | DMA read acknowledge |
| dma_data | output | DATA_W | Last captured result for the DMA channel |

## Verification
The bench builds the block with DATA_W at its default of 12. At that width the four resolution codes select 8, 10, 11 and 12 kept bits, so an all-ones result shows each mask edge directly. The 12-bit write data also reaches bits 5:4, so the control register can carry a start bit and a resolution code in one write. This makes it possible to drive the coincidence cases in a single cycle: start with trigger, and result arrival with a DMA acknowledge.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] A_STAT  = 3'd1;
    localparam logic [REG_AW-1:0] A_IEN   = 3'd2;
    localparam logic [REG_AW-1:0] A_IDIS  = 3'd3;
    localparam logic [REG_AW-1:0] A_IMASK = 3'd4;
    localparam logic [REG_AW-1:0] A_ICLR  = 3'd5;
    localparam logic [REG_AW-1:0] A_DATA  = 3'd6;

    localparam int CB_START = 0;
    localparam int CB_TRIG  = 1;
    localparam int CB_DMA   = 2;
    localparam int CB_RES   = 4;

    localparam int SB_RDY = 0;
    localparam int SB_OVR = 1;
    localparam int NSTAT  = 2;

    typedef enum logic [1:0] {
        RES_NARROW = 2'd0,
        RES_MID    = 2'd1,
        RES_WIDE   = 2'd2,
        RES_FULL   = 2'd3
    } res_e;

    function automatic int unsigned res_drop(input res_e r);
        case (r)
            RES_NARROW: return 4;
            RES_MID:    return 2;
            RES_WIDE:   return 1;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/adc_fe_trigger.sv
module adc_fe_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic trig_en,
    input  logic ext_trig,
    output logic conv_req
);

    typedef struct packed {
        logic req;
        logic trig_prev;
    } trg_s;

    trg_s s_d, s_q;
    logic rise;

    always_comb begin
        s_d           = s_q;
        rise          = ext_trig & ~s_q.trig_prev;
        s_d.trig_prev = ext_trig;
        s_d.req       = start | (trig_en & rise);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign conv_req = s_q.req;

endmodule

// File: rtl/adc_fe_status.sv
module adc_fe_status
    import adc_fe_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  res_e              res,
    input  logic              clr_rdy,
    input  logic              clr_ovr,
    input  logic              dma_en,
    input  logic              dma_ack,
    output logic              rdy,
    output logic              ovr,
    output logic              dma_req,
    output logic [DATA_W-1:0] data
);

    localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

    typedef struct packed {
        logic              rdy;
        logic              ovr;
        logic              gap;
        logic [DATA_W-1:0] data;
    } st_s;

    st_s s_d, s_q;
    logic req_int;
    logic acked;
    logic consumed;
    logic [DATA_W-1:0] keep;

    assign req_int = dma_en & s_q.rdy & ~s_q.gap;

    always_comb begin
        s_d      = s_q;
        acked    = dma_ack & req_int;
        consumed = acked | clr_rdy;
        keep     = ONES >> res_drop(res);

        s_d.gap = acked;

        if (conv_done) begin
            s_d.data = conv_data & keep;
            s_d.rdy  = 1'b1;
        end else if (consumed) begin
            s_d.rdy = 1'b0;
        end

        if (conv_done && s_q.rdy && !consumed) begin
            s_d.ovr = 1'b1;
        end else if (clr_ovr) begin
            s_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdy     = s_q.rdy;
    assign ovr     = s_q.ovr;
    assign dma_req = req_int;
    assign data    = s_q.data;

endmodule

// File: rtl/adc_fe_regs.sv
module adc_fe_regs
    import adc_fe_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              st_rdy,
    input  logic              st_ovr,
    input  logic [DATA_W-1:0] st_data,
    output logic              start,
    output logic              clr_rdy,
    output logic              clr_ovr,
    output logic              trig_en,
    output logic              dma_en,
    output res_e              res,
    output logic              irq
);

    typedef struct packed {
        logic             trig_en;
        logic             dma_en;
        res_e             res;
        logic [NSTAT-1:0] ien;
    } cfg_s;

    cfg_s c_d, c_q;
    logic [NSTAT-1:0] flags;
    logic             unused_wdata_hi;

    assign flags           = {st_ovr, st_rdy};
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CB_RES+2] ^ reg_wdata[3];

    always_comb begin
        c_d     = c_q;
        start   = 1'b0;
        clr_rdy = 1'b0;
        clr_ovr = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    start     = reg_wdata[CB_START];
                    c_d.trig_en = reg_wdata[CB_TRIG];
                    c_d.dma_en  = reg_wdata[CB_DMA];
                    c_d.res     = res_e'(reg_wdata[CB_RES +: 2]);
                end
                A_IEN:  c_d.ien = c_q.ien | reg_wdata[NSTAT-1:0];
                A_IDIS: c_d.ien = c_q.ien & ~reg_wdata[NSTAT-1:0];
                A_ICLR: begin
                    clr_rdy = reg_wdata[SB_RDY];
                    clr_ovr = reg_wdata[SB_OVR];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CB_TRIG]     = c_q.trig_en;
                reg_rdata[CB_DMA]      = c_q.dma_en;
                reg_rdata[CB_RES +: 2] = c_q.res;
            end
            A_STAT:  reg_rdata[NSTAT-1:0] = flags;
            A_IMASK: reg_rdata[NSTAT-1:0] = c_q.ien;
            A_DATA:  reg_rdata = st_data;
            default: ;
        endcase
    end

    assign trig_en = c_q.trig_en;
    assign dma_en  = c_q.dma_en;
    assign res     = c_q.res;
    assign irq     = |(flags & c_q.ien);

endmodule

// File: rtl/adc_result_frontend.sv
module adc_result_frontend
    import adc_fe_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ext_trig,
    output logic              conv_req,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              irq,
    output logic              dma_req,
    input  logic              dma_ack,
    output logic [DATA_W-1:0] dma_data
);

    logic              start_w;
    logic              clr_rdy_w;
    logic              clr_ovr_w;
    logic              trig_en_w;
    logic              dma_en_w;
    res_e              res_w;
    logic              st_rdy;
    logic              st_ovr;
    logic [DATA_W-1:0] st_data;

    adc_fe_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .st_rdy    (st_rdy),
        .st_ovr    (st_ovr),
        .st_data   (st_data),
        .start     (start_w),
        .clr_rdy   (clr_rdy_w),
        .clr_ovr   (clr_ovr_w),
        .trig_en   (trig_en_w),
        .dma_en    (dma_en_w),
        .res       (res_w),
        .irq       (irq)
    );

    adc_fe_trigger u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_w),
        .trig_en  (trig_en_w),
        .ext_trig (ext_trig),
        .conv_req (conv_req)
    );

    adc_fe_status #(.DATA_W(DATA_W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .res       (res_w),
        .clr_rdy   (clr_rdy_w),
        .clr_ovr   (clr_ovr_w),
        .dma_en    (dma_en_w),
        .dma_ack   (dma_ack),
        .rdy       (st_rdy),
        .ovr       (st_ovr),
        .dma_req   (dma_req),
        .data      (st_data)
    );

    assign dma_data = st_data;

endmodule

// File: rtl/adc_fe_checker.sv
module adc_fe_checker
    import adc_fe_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              ext_trig,
    input logic              conv_req,
    input logic              conv_done,
    input logic              dma_ack,
    input logic              dma_req,
    input logic [DATA_W-1:0] dma_data,
    input logic              irq,
    input logic              rdy,
    input logic              ovr
);

    logic wr_start, wr_clr_rdy, wr_clr_ovr, wr_ien;
    assign wr_start   = reg_wr && reg_addr == A_CTRL && reg_wdata[CB_START];
    assign wr_clr_rdy = reg_wr && reg_addr == A_ICLR && reg_wdata[SB_RDY];
    assign wr_clr_ovr = reg_wr && reg_addr == A_ICLR && reg_wdata[SB_OVR];
    assign wr_ien     = reg_wr && reg_addr == A_IEN;

    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> $past(wr_start) || $past(ext_trig)); // R1

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(dma_data)); // R4

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && rdy && !(dma_ack && dma_req) && !wr_clr_rdy |=> ovr); // R6

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr && !wr_clr_ovr |=> ovr); // R7

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(conv_done) || $past(wr_ien)); // R8

    AST_DMA_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && dma_ack |=> !dma_req); // R10

endmodule

bind adc_result_frontend adc_fe_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ext_trig  (ext_trig),
    .conv_req  (conv_req),
    .conv_done (conv_done),
    .dma_ack   (dma_ack),
    .dma_req   (dma_req),
    .dma_data  (dma_data),
    .irq       (irq),
    .rdy       (st_rdy),
    .ovr       (st_ovr)
);

// File: tb/tb_adc_result_frontend.sv
module tb_adc_result_frontend;
    import adc_fe_pkg::*;

    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          ext_trig = 1'b0;
    logic          conv_req;
    logic          conv_done = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic          irq;
    logic          dma_req;
    logic          dma_ack = 1'b0;
    logic [DW-1:0] dma_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    adc_result_frontend #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_trig(ext_trig),
        .conv_req(conv_req), .conv_done(conv_done), .conv_data(conv_data),
        .irq(irq), .dma_req(dma_req), .dma_ack(dma_ack), .dma_data(dma_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic done(input logic [DW-1:0] d);
        @(negedge clk);
        conv_done = 1'b1; conv_data = d;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        check("R1 reset conv_req", conv_req, 0);
        check("R8 reset irq", irq, 0);
        check("R10 reset dma_req", dma_req, 0);
        rd(A_STAT, v);  check("R5 reset status", v, 0);
        rd(A_DATA, v);  check("R4 reset data", v, 0);
    endtask

    task automatic t_start();
        int v;
        wr(A_CTRL, 12'h035);
        check("R1 start pulse", conv_req, 1);
        rd(A_CTRL, v); check("R1 ctrl readback", v, 12'h034);
        @(negedge clk);
        check("R1 pulse one cycle", conv_req, 0);
        wr(A_CTRL, 12'h030);
    endtask

    task automatic t_trigger();
        wr(A_CTRL, 12'h000);
        ext_trig = 1'b1;
        @(negedge clk); check("R2 trigger ignored when disabled", conv_req, 0);
        @(negedge clk); check("R2 trigger ignored when disabled", conv_req, 0);
        ext_trig = 1'b0;
        wr(A_CTRL, 12'h002);
        ext_trig = 1'b1;
        @(negedge clk); check("R2 trigger edge request", conv_req, 1);
        @(negedge clk); check("R2 held trigger no repeat", conv_req, 0);
        @(negedge clk); check("R2 held trigger no repeat", conv_req, 0);
        ext_trig = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_same();
        int pulses = 0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 12'h003; ext_trig = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
        check("R3 coincident request", conv_req, 1);
        for (int i = 0; i < 4; i++) begin
            pulses += int'(conv_req);
            @(negedge clk);
        end
        ext_trig = 1'b0;
        check("R3 single pulse", pulses, 1);
        wr(A_CTRL, 12'h000);
    endtask

    task automatic t_res();
        int v;
        for (int r = 0; r < 4; r++) begin
            wr(A_CTRL, DW'(r << 4));
            done(12'hFFF);
            rd(A_DATA, v);
            check("R4 resolution mask", v, (r == 0) ? 12'h0FF : (r == 1) ? 12'h3FF :
                                           (r == 2) ? 12'h7FF : 12'hFFF);
        end
        done(12'hA5C);
        rd(A_DATA, v); check("R4 overwrite unread", v, 12'hA5C);
        wr(A_ICLR, 12'h003);
    endtask

    task automatic t_status();
        int v;
        done(12'h123);
        rd(A_STAT, v); check("R5 ready set", v, 1);
        done(12'h456);
        rd(A_STAT, v); check("R6 overrun set", v, 3);
        rd(A_DATA, v); check("R6 data overwritten", v, 12'h456);
        wr(A_ICLR, 12'h000);
        rd(A_STAT, v); check("R9 zero clear no effect", v, 3);
        wr(A_ICLR, 12'h001);
        rd(A_STAT, v); check("R7 overrun survives ready clear", v, 2);
        rd(A_DATA, v);
        rd(A_STAT, v); check("R7 overrun survives data read", v, 2);
        wr(A_ICLR, 12'h002);
        rd(A_STAT, v); check("R7 overrun cleared", v, 0);
    endtask

    task automatic t_irq();
        int v;
        done(12'h011);
        check("R8 masked no irq", irq, 0);
        wr(A_IEN, 12'h001);
        check("R8 irq on ready", irq, 1);
        rd(A_IMASK, v); check("R8 mask readback", v, 1);
        wr(A_IDIS, 12'h001);
        check("R8 irq masked again", irq, 0);
        wr(A_IEN, 12'h002);
        check("R8 no irq without overrun", irq, 0);
        done(12'h022);
        check("R8 irq on overrun", irq, 1);
        wr(A_IDIS, 12'h003);
        rd(A_IMASK, v); check("R8 mask cleared", v, 0);
        wr(A_ICLR, 12'h003);
    endtask

    task automatic t_dma();
        int v;
        wr(A_CTRL, 12'h034);
        check("R10 no request when idle", dma_req, 0);
        done(12'h321);
        check("R10 request on ready", dma_req, 1);
        check("R10 dma data", int'(dma_data), 12'h321);
        @(negedge clk);
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        check("R10 request gap after ack", dma_req, 0);
        rd(A_STAT, v); check("R10 ready cleared by ack", v, 0);
        done(12'h111);
        done(12'h222);
        rd(A_STAT, v); check("R6 overrun in dma mode", v, 3);
        @(negedge clk);
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        rd(A_STAT, v); check("R7 ack keeps overrun", v, 2);
        wr(A_ICLR, 12'h002);
        done(12'h0AA);
        @(negedge clk);
        dma_ack = 1'b1; conv_done = 1'b1; conv_data = 12'h0BB;
        @(negedge clk);
        dma_ack = 1'b0; conv_done = 1'b0;
        rd(A_STAT, v); check("R11 ready kept, no overrun", v, 1);
        rd(A_DATA, v); check("R11 new result kept", v, 12'h0BB);
        check("R11 gap after ack", dma_req, 0);
        @(negedge clk);
        check("R11 request resumes", dma_req, 1);
        wr(A_CTRL, 12'h030);
        wr(A_ICLR, 12'h003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start();
        t_trigger();
        t_same();
        t_res();
        t_status();
        t_irq();
        t_dma();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule